// File: doc/BRIEF.md
# Precise Trap Sequencer for a Five-Stage Pipeline

This block keeps traps precise in an in-order pipeline with fetch, decode, execute, memory and writeback stages. Every stage reports fault flags for the instruction it currently holds. The block records the first cause next to that instruction's PC in the stage registers, and the record travels down the pipe with the instruction. Nothing is done when a fault is first seen. The trap is taken at one fixed point: the end of the memory stage.

When a trap is taken, the block issues several results together. It pulses a take strobe. It presents the saved PC, a 4-bit cause code and the vector address that fetch must jump to. It clears the valid bit of every younger stage, and it reports which of those stages held a live instruction. The faulting instruction never reaches writeback, so its register write is suppressed. An instruction already in writeback completes normally.

An external interrupt request takes the place of the next fetch. It enters as a faulting no-op and then follows the same path as any other trap. A stall input freezes fetch and decode and sends a bubble into execute.

Top module: `pexc_ctrl`

## Requirements
- R1: After synchronous reset, all five stage valid bits are 0 and the take strobe is 0.
- R2: When there is no stall and no trap, an instruction accepted at an edge is in fetch after that edge. It moves one stage per edge and is in writeback after the fourth edge that follows.
- R3: A fault is acted on only at the end of the memory stage. The take strobe is high for one cycle, in the cycle after the instruction's memory cycle. In that cycle the saved PC equals the instruction's PC and the redirect address equals the VECTOR parameter.
- R4: The cause codes are as follows:
  - 1: interrupt.
  - 2, 3 and 4: fetch page fault (`if_fault[0]`), fetch misalignment (`if_fault[1]`) and fetch protection violation (`if_fault[2]`).
  - 5: illegal opcode (`id_illegal`).
  - 6: overflow (`ex_overflow`).
  - 7, 8, 9 and 10: data page fault (`mem_fault[0]`), data misalignment (`mem_fault[1]`), data protection violation (`mem_fault[2]`) and memory error (`mem_fault[3]`).
- R5: If one instruction picks up faults in several stages, the cause from the earliest stage is the one reported.
- R6: If several flags are raised in the same stage, the lowest-numbered flag bit wins.
- R7: When a trap is taken, the valid bits of fetch, decode, execute and memory read 0 in the take cycle, and the faulting instruction does not enter writeback. `stage_kill` shows which of those four stages (bit 0 = fetch up to bit 3 = memory) held a valid instruction at the commit edge.
- R8: If several in-flight instructions carry faults, only the oldest one traps. Younger faulting instructions are squashed and never raise a second take.
- R9: An instruction ahead of the faulting one completes: it is valid in writeback.
- R10: An asserted `irq` replaces the fetch slot with a no-op that carries `fetch_pc`. That no-op traps with cause 1 four edges after it enters.
- R11: An `irq` raised during the take cycle is ignored. A fetch in that cycle enters as an ordinary instruction and does not trap.
- R12: While `stall` is high and no trap commits, fetch and decode hold their contents and execute receives a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | An instruction is fetched at this edge |
| fetch_pc | input | 32 | PC of the fetched instruction or interrupt slot |
| irq | input | 1 | External interrupt request |
| stall | input | 1 | Hold fetch and decode, bubble into execute |
| if_fault | input | 3 | Fetch-stage fault flags |
| id_illegal | input | 1 | Decode-stage illegal opcode |
| ex_overflow | input | 1 | Execute-stage arithmetic overflow |
| mem_fault | input | 4 | Memory-stage fault flags |
| exc_take | output | 1 | One-cycle trap strobe |
| epc | output | 32 | PC of the trapping instruction |
| exc_cause | output | 4 | Cause code of the trap |
| redirect_pc | output | 32 | Vector address for fetch |
| stage_valid | output | 5 | Valid bits: fetch (bit 0) to writeback (bit 4) |
| stage_kill | output | 4 | Stages squashed at the trap (bit 0 fetch to bit 3 memory) |

## Verification
Inputs are driven on the falling edge. Each fault flag is driven in the one cycle during which the target instruction sits in the matching stage: one, two, three or four falling edges after the fetch is driven. The trap result is registered, so it is checked at the fifth falling edge after fetch. That is the first sample point after the commit edge.

The checks around that point follow from the same rule:
- The edge after an oldest-wins flush is checked to show no second strobe.
- An instruction ahead of the trap is checked in writeback one falling edge before the strobe.
- Stall hold and bubble are sampled right after each stalled edge.

// File: rtl/pexc_pkg.sv
package pexc_pkg;

    localparam int PC_W    = 32;
    localparam int CAUSE_W = 4;

    typedef enum logic [CAUSE_W-1:0] {
        CS_NONE    = 4'd0,
        CS_IRQ     = 4'd1,
        CS_IPAGE   = 4'd2,
        CS_IALIGN  = 4'd3,
        CS_IPROT   = 4'd4,
        CS_ILLEGAL = 4'd5,
        CS_OVF     = 4'd6,
        CS_DPAGE   = 4'd7,
        CS_DALIGN  = 4'd8,
        CS_DPROT   = 4'd9,
        CS_MEMERR  = 4'd10
    } cause_e;

    typedef struct packed {
        logic            valid;
        logic [PC_W-1:0] pc;
        cause_e          cause;
    } slot_t;

    // earlier recorded cause keeps priority over a later stage's cause
    function automatic slot_t fold_cause(slot_t s, cause_e here);
        slot_t r;
        r = s;
        if (s.valid && s.cause == CS_NONE)
            r.cause = here;
        return r;
    endfunction

endpackage

// File: rtl/pexc_cause_enc.sv
module pexc_cause_enc
    import pexc_pkg::*;
#(
    parameter int N    = 1,
    parameter int BASE = 2
) (
    input  logic [N-1:0] flags,
    output cause_e       cause
);
    // lowest flag index wins: scan from top so the lowest set bit lands last
    always_comb begin
        cause = CS_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (flags[i])
                cause = cause_e'(BASE + i);
        end
    end
endmodule

// File: rtl/pexc_commit_unit.sv
module pexc_commit_unit
    import pexc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            commit_now,
    input  logic [PC_W-1:0] commit_pc,
    input  cause_e          commit_cause,
    input  logic [3:0]      live,
    output logic            take_q,
    output logic [PC_W-1:0] epc_q,
    output cause_e          cause_q,
    output logic [3:0]      kill_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            take_q  <= 1'b0;
            epc_q   <= '0;
            cause_q <= CS_NONE;
            kill_q  <= '0;
        end else begin
            take_q <= commit_now;
            kill_q <= commit_now ? live : 4'b0000;
            if (commit_now) begin
                epc_q   <= commit_pc;
                cause_q <= commit_cause;
            end
        end
    end

    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        take_q |=> !take_q); // R3

    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (cause_q != CS_NONE)); // R4

    AST_MEM_KILLED: assert property (@(posedge clk) disable iff (rst)
        take_q |-> kill_q[3]); // R7
endmodule

// File: rtl/pexc_ctrl.sv
module pexc_ctrl
    import pexc_pkg::*;
#(
    parameter logic [31:0] VECTOR = 32'h0000_0080
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_pc,
    input  logic        irq,
    input  logic        stall,
    input  logic [2:0]  if_fault,
    input  logic        id_illegal,
    input  logic        ex_overflow,
    input  logic [3:0]  mem_fault,
    output logic        exc_take,
    output logic [31:0] epc,
    output logic [3:0]  exc_cause,
    output logic [31:0] redirect_pc,
    output logic [4:0]  stage_valid,
    output logic [3:0]  stage_kill
);
    slot_t  if_q, id_q, ex_q, mem_q, wb_q;
    cause_e if_c, id_c, ex_c, mem_c;
    slot_t  id_n, ex_n, mem_n, mem_fin, fetch_slot;
    cause_e cause_out;
    logic   commit_now, irq_ok;

    pexc_cause_enc #(.N(3), .BASE(2)) u_enc_if  (.flags(if_fault),    .cause(if_c));
    pexc_cause_enc #(.N(1), .BASE(5)) u_enc_id  (.flags(id_illegal),  .cause(id_c));
    pexc_cause_enc #(.N(1), .BASE(6)) u_enc_ex  (.flags(ex_overflow), .cause(ex_c));
    pexc_cause_enc #(.N(4), .BASE(7)) u_enc_mem (.flags(mem_fault),   .cause(mem_c));

    assign id_n    = fold_cause(if_q,  if_c);
    assign ex_n    = fold_cause(id_q,  id_c);
    assign mem_n   = fold_cause(ex_q,  ex_c);
    assign mem_fin = fold_cause(mem_q, mem_c);

    assign commit_now = mem_fin.valid && (mem_fin.cause != CS_NONE);
    assign irq_ok     = irq && !exc_take;

    always_comb begin
        fetch_slot.valid = fetch_valid || irq_ok;
        fetch_slot.pc    = fetch_pc;
        fetch_slot.cause = irq_ok ? CS_IRQ : CS_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst || commit_now) begin
            if_q  <= '0;
            id_q  <= '0;
            ex_q  <= '0;
            mem_q <= '0;
            wb_q  <= '0;
        end else if (stall) begin
            ex_q  <= '0;
            mem_q <= mem_n;
            wb_q  <= mem_fin;
        end else begin
            if_q  <= fetch_slot;
            id_q  <= id_n;
            ex_q  <= ex_n;
            mem_q <= mem_n;
            wb_q  <= mem_fin;
        end
    end

    pexc_commit_unit u_commit (
        .clk         (clk),
        .rst         (rst),
        .commit_now  (commit_now),
        .commit_pc   (mem_fin.pc),
        .commit_cause(mem_fin.cause),
        .live        ({mem_q.valid, ex_q.valid, id_q.valid, if_q.valid}),
        .take_q      (exc_take),
        .epc_q       (epc),
        .cause_q     (cause_out),
        .kill_q      (stage_kill)
    );

    assign exc_cause   = cause_out;
    assign redirect_pc = VECTOR;
    assign stage_valid = {wb_q.valid, mem_q.valid, ex_q.valid, id_q.valid, if_q.valid};

    AST_FLUSH_YOUNGER: assert property (@(posedge clk) disable iff (rst)
        exc_take |-> (stage_valid[3:0] == 4'b0000)); // R7

    AST_NO_FAULT_WB: assert property (@(posedge clk) disable iff (rst)
        commit_now |=> !wb_q.valid); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stall && !commit_now) |=> ($stable(if_q) && $stable(id_q))); // R12

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (stall && !commit_now) |=> !ex_q.valid); // R12

    AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> (if_q.cause != CS_IRQ)); // R11
endmodule

// File: tb/pexc_ctrl_bench.sv
`timescale 1ns/1ps
module pexc_ctrl_bench;
    localparam logic [31:0] VEC = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_valid, irq, stall, id_illegal, ex_overflow;
    logic [31:0] fetch_pc;
    logic [2:0]  if_fault;
    logic [3:0]  mem_fault;
    logic        exc_take;
    logic [31:0] epc, redirect_pc;
    logic [3:0]  exc_cause, stage_kill;
    logic [4:0]  stage_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pexc_ctrl #(.VECTOR(VEC)) u_pexc_ctrl (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .irq(irq), .stall(stall), .if_fault(if_fault), .id_illegal(id_illegal),
        .ex_overflow(ex_overflow), .mem_fault(mem_fault), .exc_take(exc_take),
        .epc(epc), .exc_cause(exc_cause), .redirect_pc(redirect_pc),
        .stage_valid(stage_valid), .stage_kill(stage_kill)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] want_cause(logic [2:0] fi, logic fd, logic fe, logic [3:0] fm);
        if (fi[0]) return 4'd2;
        if (fi[1]) return 4'd3;
        if (fi[2]) return 4'd4;
        if (fd)    return 4'd5;
        if (fe)    return 4'd6;
        if (fm[0]) return 4'd7;
        if (fm[1]) return 4'd8;
        if (fm[2]) return 4'd9;
        if (fm[3]) return 4'd10;
        return 4'd0;
    endfunction

    task automatic idle_inputs();
        fetch_valid = 0; irq = 0; stall = 0; id_illegal = 0; ex_overflow = 0;
        if_fault = 0; mem_fault = 0; fetch_pc = 0;
    endtask

    // one instruction, flags driven in the cycle it occupies each stage
    task automatic run_one(input logic [31:0] pc, input logic [2:0] fi, input logic fd,
                           input logic fe, input logic [3:0] fm);
        logic [3:0] exp_c;
        exp_c = want_cause(fi, fd, fe, fm);
        @(negedge clk); fetch_valid = 1; fetch_pc = pc;
        @(negedge clk); fetch_valid = 0; if_fault = fi;
        @(negedge clk); if_fault = 0; id_illegal = fd;
        @(negedge clk); id_illegal = 0; ex_overflow = fe;
        chk(exc_take == 0, "R3 no early take", exc_take, 0);
        @(negedge clk); ex_overflow = 0; mem_fault = fm;
        chk(exc_take == 0, "R3 no early take", exc_take, 0);
        @(negedge clk); mem_fault = 0;
        if (exp_c != 0) begin
            chk(exc_take == 1, "R3 take strobe", exc_take, 1);
            chk(epc == pc, "R3 epc", epc, pc);
            chk(redirect_pc == VEC, "R3 redirect", redirect_pc, VEC);
            chk(exc_cause == exp_c, "R4 R5 R6 cause", exc_cause, exp_c);
            chk(stage_valid == 5'b0, "R7 flushed, no writeback", stage_valid, 0);
            chk(stage_kill == 4'b1000, "R7 kill bits", stage_kill, 4'b1000);
        end else begin
            chk(exc_take == 0, "R2 no take", exc_take, 0);
            chk(stage_valid == 5'b10000, "R2 in writeback", stage_valid, 5'b10000);
        end
        @(negedge clk);
        chk(exc_take == 0, "R3 single pulse", exc_take, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        chk(stage_valid == 0, "R1 valid after reset", stage_valid, 0);
        chk(exc_take == 0, "R1 take after reset", exc_take, 0);

        // R2: stage progression
        @(negedge clk); fetch_valid = 1; fetch_pc = 32'h100;
        @(negedge clk); fetch_valid = 0;
        chk(stage_valid == 5'b00001, "R2 fetch", stage_valid, 5'b00001);
        @(negedge clk);
        chk(stage_valid == 5'b00010, "R2 decode", stage_valid, 5'b00010);
        @(negedge clk);
        chk(stage_valid == 5'b00100, "R2 execute", stage_valid, 5'b00100);
        @(negedge clk);
        chk(stage_valid == 5'b01000, "R2 memory", stage_valid, 5'b01000);
        @(negedge clk);
        chk(stage_valid == 5'b10000, "R2 writeback", stage_valid, 5'b10000);
        @(negedge clk);

        // R3 R4 R5 R6: sweep over all flag combinations
        for (int fi = 0; fi < 8; fi++)
            for (int fd = 0; fd < 2; fd++)
                for (int fe = 0; fe < 2; fe++)
                    for (int fm = 0; fm < 16; fm++)
                        run_one(32'h1000 + 32'(fi*64 + fd*32 + fe*16 + fm) * 4,
                                3'(fi), 1'(fd), 1'(fe), 4'(fm));

        // R8: A faults in memory, younger B faults in fetch
        @(negedge clk); fetch_valid = 1; fetch_pc = 32'hA000;
        @(negedge clk); fetch_pc = 32'hB000;
        @(negedge clk); fetch_valid = 0; if_fault = 3'b001;
        @(negedge clk); if_fault = 0;
        @(negedge clk); mem_fault = 4'b1000;
        @(negedge clk); mem_fault = 0;
        chk(exc_take == 1, "R8 oldest takes", exc_take, 1);
        chk(epc == 32'hA000, "R8 oldest epc", epc, 32'hA000);
        chk(exc_cause == 4'd10, "R8 oldest cause", exc_cause, 10);
        chk(stage_kill == 4'b1100, "R7 kill shows younger", stage_kill, 4'b1100);
        repeat (5) begin
            @(negedge clk);
            chk(exc_take == 0, "R8 younger squashed", exc_take, 0);
        end

        // R9: older A clean, younger B overflows
        @(negedge clk); fetch_valid = 1; fetch_pc = 32'hC000;
        @(negedge clk); fetch_pc = 32'hC004;
        @(negedge clk); fetch_valid = 0;
        @(negedge clk);
        @(negedge clk); ex_overflow = 1;
        @(negedge clk); ex_overflow = 0;
        chk(stage_valid[4] == 1, "R9 older in writeback", stage_valid, 5'b11000);
        chk(exc_take == 0, "R9 not yet", exc_take, 0);
        @(negedge clk);
        chk(exc_take == 1 && epc == 32'hC004, "R9 younger traps", epc, 32'hC004);
        chk(exc_cause == 4'd6, "R9 cause", exc_cause, 6);
        @(negedge clk);

        // R10: interrupt no-op
        @(negedge clk); irq = 1; fetch_valid = 1; fetch_pc = 32'hD000;
        @(negedge clk); irq = 0; fetch_valid = 0;
        chk(stage_valid == 5'b00001, "R10 no-op in fetch", stage_valid, 1);
        repeat (4) @(negedge clk);
        chk(exc_take == 1, "R10 irq take", exc_take, 1);
        chk(exc_cause == 4'd1, "R10 irq cause", exc_cause, 1);
        chk(epc == 32'hD000, "R10 irq epc", epc, 32'hD000);

        // R11: irq in take cycle ignored
        irq = 1; fetch_valid = 1; fetch_pc = 32'hE000;
        @(negedge clk); irq = 0; fetch_valid = 0;
        chk(stage_valid == 5'b00001, "R11 plain fetch enters", stage_valid, 1);
        repeat (4) begin
            @(negedge clk);
            chk(exc_take == 0, "R11 irq ignored", exc_take, 0);
        end
        chk(stage_valid == 5'b10000, "R11 completes", stage_valid, 5'b10000);
        @(negedge clk);

        // R12: stall holds fetch/decode, bubbles execute
        @(negedge clk); fetch_valid = 1; fetch_pc = 32'hF000;
        @(negedge clk); fetch_pc = 32'hF004;
        @(negedge clk); fetch_valid = 0; stall = 1;
        @(negedge clk);
        chk(stage_valid == 5'b00011, "R12 hold and bubble", stage_valid, 5'b00011);
        @(negedge clk); stall = 0;
        chk(stage_valid == 5'b00011, "R12 still held", stage_valid, 5'b00011);
        @(negedge clk);
        chk(stage_valid == 5'b00110, "R12 resumed", stage_valid, 5'b00110);
        ex_overflow = 1;
        @(negedge clk); ex_overflow = 0;
        @(negedge clk);
        chk(exc_take == 1 && epc == 32'hF000, "R12 held instr traps", epc, 32'hF000);
        chk(stage_kill == 4'b1100, "R12 kill after stall", stage_kill, 4'b1100);
        @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule